// File: doc/BRIEF.md
# Byte-Accessed 16-bit Reloading Timer

This block is a 16-bit up-counter with a programmable reload limit. Software reaches it over an 8-bit register port. The counter advances by one on every clock while the enable input is high. When the count equals the reload limit, the next clock returns the count to 0x0001 and a terminal-count pulse is raised for one cycle. The block has no prescaler, no modes beyond free counting, and no interrupt or pin logic. Those functions sit around it.

Software sees the count and the reload limit as byte pairs. Reads and reload writes stay coherent as 16-bit quantities:
- **Reads.** While the timer runs, reading the upper count byte snapshots the lower byte into a holding register. The next read of the lower byte returns that snapshot.
- **Reload writes.** A write to the upper reload byte is only staged. It takes effect, together with the lower byte, when the lower reload byte is written.
- **Count writes.** Writes to the count bytes are not staged. Each one lands at the next clock edge.

Top module: `tmr16_regs`

## Requirements
- R1: After reset the count is 0x0001 (offset 0 reads 0x00, offset 1 reads 0x01), the reload limit is 0xFFFF (offsets 2 and 3 read 0xFF), and the terminal-count output is low.
- R2: With enable high and the count different from the reload limit, the count rises by exactly one per clock. With enable low and no count write, the count holds its value.
- R3: With enable high and the count equal to the reload limit, the next clock sets the count to 0x0001 and drives the terminal-count output high for that cycle. With enable low, the terminal-count output stays low.
- R4: A read of offset 0 returns the upper count byte. While enable is high, the same read copies the current lower count byte into the holding register at the clock edge.
- R5: While enable is high, a read of offset 1 returns the holding register, not the live lower count byte.
- R6: While enable is low, a read of offset 1 returns the live lower count byte.
- R7: A write to offset 0 (upper) or offset 1 (lower) replaces that count byte at the next clock edge. If the counter also steps in that cycle, the other byte takes its stepped value, and counting continues from the result.
- R8: A write to offset 2 only stages the byte. The reload limit read back at offsets 2 and 3 does not change.
- R9: A write to offset 3 sets the reload limit to {staged byte, written byte} in a single clock edge.
- R10: Reads of offsets 4 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Count enable; also selects snapshot reads of the lower byte |
| addr | input | 3 | Register offset |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one access per cycle |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data for the current offset (combinational) |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |

## Verification
The bound checker watches every cycle for:
- the single-step increment and the hold while disabled;
- the return to 0x0001 with its pulse;
- the reload limit staying put after a staged upper-byte write;
- the lower reload byte committing;
- live lower-byte reads while disabled;
- zero reads from unmapped offsets.

Only the bench scenarios show the effects that span several accesses:
- the snapshot that keeps an upper-then-lower read coherent across a carry from 0x00FF to 0x0100;
- the count byte-write priority over a concurrent step;
- the full wrap arithmetic and pulse totals over a sweep of run lengths against a small reload limit.

// File: rtl/tmr16_pkg.sv
`timescale 1ns/1ps
package tmr16_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(1);
    localparam logic [CNT_W-1:0] RLD_RST = '1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  rld;
        logic [BYTE_W-1:0] stage;
        logic [BYTE_W-1:0] hold;
        logic              tc;
    } tmr_state_t;
endpackage

// File: rtl/tmr16_step.sv
`timescale 1ns/1ps
module tmr16_step
    import tmr16_pkg::*;
(
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  rld_q,
    input  logic              en,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_d,
    output logic              tc_d
);
    logic hit;
    logic [CNT_W-1:0] stepped;

    always_comb begin
        hit     = (cnt_q == rld_q);
        stepped = cnt_q;
        if (en) begin
            stepped = hit ? CNT_RST : cnt_q + CNT_W'(1);
        end
        tc_d  = en && hit;
        cnt_d = stepped;
        if (wr_hi) begin
            cnt_d[CNT_W-1:BYTE_W] = wdata;
        end
        if (wr_lo) begin
            cnt_d[BYTE_W-1:0] = wdata;
        end
    end
endmodule

// File: rtl/tmr16_rdmux.sv
`timescale 1ns/1ps
module tmr16_rdmux
    import tmr16_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              en,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [CNT_W-1:0]  rld_q,
    input  logic [BYTE_W-1:0] hold_q,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(0): rdata = cnt_q[CNT_W-1:BYTE_W];
            ADDR_W'(1): rdata = en ? hold_q : cnt_q[BYTE_W-1:0];
            ADDR_W'(2): rdata = rld_q[CNT_W-1:BYTE_W];
            ADDR_W'(3): rdata = rld_q[BYTE_W-1:0];
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr16_regs.sv
`timescale 1ns/1ps
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [BYTE_W-1:0] rdata,
    output logic              tc_pulse
);
    localparam logic [ADDR_W-1:0] OFS_CHI = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_CLO = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_RHI = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] OFS_RLO = ADDR_W'(3);

    tmr_state_t st_d, st_q;

    logic [CNT_W-1:0] cnt_step_d;
    logic             tc_step_d;
    logic             wr_chi, wr_clo;

    assign wr_chi = wr && (addr == OFS_CHI);
    assign wr_clo = wr && (addr == OFS_CLO);

    tmr16_step u_step (
        .cnt_q (st_q.cnt),
        .rld_q (st_q.rld),
        .en    (en),
        .wr_hi (wr_chi),
        .wr_lo (wr_clo),
        .wdata (wdata),
        .cnt_d (cnt_step_d),
        .tc_d  (tc_step_d)
    );

    tmr16_rdmux #(.ADDR_W(ADDR_W)) u_rdmux (
        .addr   (addr),
        .en     (en),
        .cnt_q  (st_q.cnt),
        .rld_q  (st_q.rld),
        .hold_q (st_q.hold),
        .rdata  (rdata)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = cnt_step_d;
        st_d.tc  = tc_step_d;
        if (rd && en && (addr == OFS_CHI)) begin
            st_d.hold = st_q.cnt[BYTE_W-1:0];
        end
        if (wr && (addr == OFS_RHI)) begin
            st_d.stage = wdata;
        end
        if (wr && (addr == OFS_RLO)) begin
            st_d.rld = {st_q.stage, wdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= CNT_RST;
            st_q.rld   <= RLD_RST;
            st_q.stage <= '0;
            st_q.hold  <= '0;
            st_q.tc    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_pulse = st_q.tc;
endmodule

// File: rtl/tmr16_chk.sv
`timescale 1ns/1ps
module tmr16_chk
    import tmr16_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en,
    input logic [ADDR_W-1:0] addr,
    input logic [BYTE_W-1:0] wdata,
    input logic              wr,
    input logic              rd,
    input logic [BYTE_W-1:0] rdata,
    input logic              tc,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  rld
);
    logic cwr;
    assign cwr = wr && (addr <= ADDR_W'(1));

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt != rld && !cwr) |=> (cnt == $past(cnt) + CNT_W'(1))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cwr) |=> $stable(cnt)); // R2
    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == rld && !cwr) |=> (cnt == CNT_W'(1) && tc)); // R3
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tc); // R3
    AST_LIVE_LOW_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && rd && addr == ADDR_W'(1)) |-> (rdata == cnt[BYTE_W-1:0])); // R6
    AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(2)) |=> $stable(rld)); // R8
    AST_COMMIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADDR_W'(3)) |=> (rld[BYTE_W-1:0] == $past(wdata))); // R9
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr >= ADDR_W'(4)) |-> (rdata == '0)); // R10
endmodule

bind tmr16_regs tmr16_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .addr  (addr),
    .wdata (wdata),
    .wr    (wr),
    .rd    (rd),
    .rdata (rdata),
    .tc    (tc_pulse),
    .cnt   (st_q.cnt),
    .rld   (st_q.rld)
);

// File: tb/sim_tmr16_regs.sv
`timescale 1ns/1ps
module sim_tmr16_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       tc_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int tc_seen = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tmr16_regs #(.ADDR_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .addr(addr), .wdata(wdata),
        .wr(wr), .rd(rd), .rdata(rdata), .tc_pulse(tc_pulse)
    );

    always @(negedge clk) if (rst_n && tc_pulse) tc_seen++;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1; #2 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic rcnt(output logic [15:0] v);
        logic [7:0] h, l;
        rreg(3'd0, h);
        rreg(3'd1, l);
        v = {h, l};
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values, R10 unmapped offsets
        chk("R1 tc", int'(tc_pulse), 0);
        rreg(3'd0, b); chk("R1 cnt hi", b, 8'h00);
        rreg(3'd1, b); chk("R1 cnt lo", b, 8'h01);
        rreg(3'd2, b); chk("R1 rld hi", b, 8'hFF);
        rreg(3'd3, b); chk("R1 rld lo", b, 8'hFF);
        for (int a = 4; a < 8; a++) begin
            rreg(3'(a), b); chk("R10 unmapped", b, 8'h00);
        end

        // R7 writes while disabled, R6 live reads, R2 hold while disabled
        wreg(3'd0, 8'h12); wreg(3'd1, 8'h34);
        repeat (5) @(negedge clk);
        rcnt(v); chk("R2 R6 R7 idle hold", v, 16'h1234);

        // R8 staging, R9 commit
        wreg(3'd2, 8'h00);
        rreg(3'd2, b); chk("R8 rld hi unchanged", b, 8'hFF);
        rreg(3'd3, b); chk("R8 rld lo unchanged", b, 8'hFF);
        wreg(3'd3, 8'h20);
        rreg(3'd2, b); chk("R9 rld hi", b, 8'h00);
        rreg(3'd3, b); chk("R9 rld lo", b, 8'h20);

        // R2 R3 sweep of run lengths against reload 0x0020 starting from 0
        for (int k = 1; k <= 70; k++) begin
            int exp_c, exp_t;
            wreg(3'd0, 8'h00); wreg(3'd1, 8'h00);
            tc_seen = 0;
            @(negedge clk); en = 1'b1;
            repeat (k) @(negedge clk);
            en = 1'b0;
            @(negedge clk);
            exp_c = (k <= 32) ? k : ((k - 33) % 32) + 1;
            exp_t = (k <= 32) ? 0 : ((k - 33) / 32) + 1;
            rcnt(v);
            chk("R2 R3 sweep count", v, exp_c);
            chk("R3 sweep pulses", tc_seen, exp_t);
        end

        // R4 R5 R6 coherent read across a carry, reload 0xFFFF
        wreg(3'd2, 8'hFF); wreg(3'd3, 8'hFF);
        wreg(3'd0, 8'h00); wreg(3'd1, 8'hFE);
        @(negedge clk); en = 1'b1;              // next edge: 0x00FF
        @(negedge clk); addr = 3'd0; rd = 1'b1; // edge: hold=FF, cnt 0x0100
        #2 chk("R4 upper byte", rdata, 8'h00);
        @(negedge clk); addr = 3'd1;            // cnt 0x0100, edge to 0x0101
        #2 chk("R5 snapshot low", rdata, 8'hFF);
        @(negedge clk);                         // cnt 0x0101
        #2 chk("R5 snapshot kept", rdata, 8'hFF);
        @(negedge clk); en = 1'b0;              // cnt 0x0102, frozen
        #2 chk("R6 live low after disable", rdata, 8'h02);
        @(negedge clk); rd = 1'b0;

        // R7 byte write priority over a concurrent step
        wreg(3'd0, 8'h05); wreg(3'd1, 8'hFF);
        @(negedge clk); en = 1'b1; addr = 3'd1; wdata = 8'h10; wr = 1'b1;
        @(negedge clk); en = 1'b0; wr = 1'b0;
        rcnt(v); chk("R7 low write, high stepped", v, 16'h0610);
        wreg(3'd0, 8'h00); wreg(3'd1, 8'h10);
        @(negedge clk); en = 1'b1; addr = 3'd0; wdata = 8'h7A; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
        @(negedge clk); en = 1'b0;
        rcnt(v); chk("R7 high write then continue", v, 16'h7A12);

        done = 1'b1;
        summary();
    end
endmodule